// File: doc/BRIEF.md
# Strided Masked Vector Engine

The engine runs one vector instruction at a time over operands kept in a private 256-word memory of 16-bit words. A command gives an operation, an operand form, a scalar, a mask-enable flag and three descriptors (first source, second source, destination). Each descriptor has a base address, a signed 8-bit stride and a length, so element k (counted from 0) of that operand sits at `base + k*stride`, wrapped modulo 256. The host fills and inspects the memory through a word port while the engine is idle, then issues a command and waits for `done`.

Each instruction passes through named states. IDLE waits for `cmd_valid`. ACCEPT_OK takes a legal command from IDLE to LOAD, and ACCEPT_BAD takes an illegal one straight to FINISH. LOAD_END moves from LOAD to EXEC once every source element has been read into the operand buffers. EXEC_TO_STORE leaves EXEC for STORE when the result is a vector, and EXEC_TO_FINISH goes to FINISH when the result is a scalar. STORE_END moves from STORE to FINISH. FINISH raises `done` for one cycle and returns to IDLE. Every source element is buffered before the first destination write, so overlapping ranges behave as whole-vector assignments. A 32-bit mask register, loaded by compare instructions, can gate which destination elements are written. The work done never depends on the mask.

Top module: `svec_engine`

## Requirements
- R1: Element k (k = 0..N-1) of an operand is at address (base + k*stride) mod 256, with the stride taken as signed 8-bit two's complement. Each operand uses its own base and stride.
- R2: A command is rejected when its operation code is above 4, when the first source length is 0 or above 32, or when the lengths the form uses differ. The form rules are: form 0 needs all three lengths equal, form 1 needs the first source and destination lengths equal, and form 3 needs both source lengths equal. A rejected command raises `done` and `error` together on the cycle after acceptance and changes neither memory, mask nor `result`.
- R3: Operation codes are 0 add, 1 subtract (first minus second), 2 AND, 3 OR and 4 greater-than-zero. Code 4 gives 1 when the first operand is signed-positive, otherwise 0, and ignores the second operand. Form 0 writes `dst[k] = A[k] op B[k]`. Form 1 writes `dst[k] = A[k] op scalar`.
- R4: Form 2 reduces the first source to a scalar with an accumulator that starts at 0. Codes 0..3 apply `acc = acc op A[k]` in order. Code 4 counts the signed-positive elements.
- R5: Form 3 gives the sum, modulo 2^16, of `A[k] op B[k]` over all k.
- R6: All source elements are read before any destination element is written, so a destination that overlaps a source sees only the old source values.
- R7: With mask enable set, destination element k is written only when mask bit k is 1 and is left unchanged otherwise. With mask enable clear, every element is written.
- R8: The mask register resets to all ones. A code-4 instruction in form 0 or 1 loads bit k with the compare result for k < N and clears bits N..31. That instruction's own store uses the mask value from before it.
- R9: For a legal command, `done` rises 3N cycles after the accepting edge in forms 0 and 1, and 2N cycles after it in forms 2 and 3, whatever the mask holds.
- R10: `busy` is high from the accepting edge through the `done` cycle. `done` lasts one cycle. `cmd_valid` is ignored while busy.
- R11: A `mem_we` write takes effect only while the engine is idle and is dropped while busy. `mem_rdata` shows the word at `mem_addr` in the same cycle.
- R12: `result` resets to 0, takes the scalar of a legal form 2 or 3 instruction in its `done` cycle, and holds that value until the next such instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 3 | Operation code |
| cmd_form | input | 2 | Operand form 0..3 |
| cmd_mask_en | input | 1 | Gate destination writes with the mask register |
| cmd_scalar | input | 16 | Scalar operand for form 1 |
| a_base | input | 8 | First source base address |
| a_stride | input | 8 | First source signed stride |
| a_len | input | 6 | First source length |
| b_base | input | 8 | Second source base address |
| b_stride | input | 8 | Second source signed stride |
| b_len | input | 6 | Second source length |
| d_base | input | 8 | Destination base address |
| d_stride | input | 8 | Destination signed stride |
| d_len | input | 6 | Destination length |
| mem_we | input | 1 | Host write enable |
| mem_addr | input | 8 | Host word address |
| mem_wdata | input | 16 | Host write data |
| mem_rdata | output | 16 | Word at `mem_addr` |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Command was rejected, valid with `done` |
| result | output | 16 | Scalar from the last reduction |

## Verification
The host write port and the engine's store phase both drive the single memory write path, and a new command can arrive while an instruction is still running. The bench raises `mem_we` at a destination address and pulses `cmd_valid` with an illegal operation code, both in the same cycle and in the middle of STORE. It then checks that the full memory image matches a model in which the host write never happened. It also checks that the instruction completes on its normal cycle count with no error and that no second `done` follows. A sweep over operations, forms, lengths, strides and mask settings compares the whole memory, the mask effects, `result` and the cycle count against an arithmetic model after each instruction.

// File: rtl/svec_pkg.sv
package svec_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_GTZ = 3'd4
    } vop_e;

    typedef enum logic [1:0] {
        FM_VVV  = 2'd0,
        FM_VSV  = 2'd1,
        FM_RED1 = 2'd2,
        FM_RED2 = 2'd3
    } vform_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_EXEC,
        S_STORE,
        S_FINISH
    } vstate_e;

    localparam int NUM_DESC = 3;

endpackage

// File: rtl/svec_agu.sv
module svec_agu #(
    parameter int AW = 8,
    parameter int SW = 8,
    parameter int IW = 5
) (
    input  logic [AW-1:0] base,
    input  logic [SW-1:0] stride,
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] addr
);
    logic signed [AW-1:0] offset;

    always_comb begin
        offset = AW'($signed({1'b0, idx})) * AW'($signed(stride));
        addr   = base + offset;
    end
endmodule

// File: rtl/svec_alu.sv
module svec_alu
    import svec_pkg::*;
#(
    parameter int DW = 16
) (
    input  vop_e          op,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] res
);
    always_comb begin
        unique case (op)
            OP_ADD:  res = opa + opb;
            OP_SUB:  res = opa - opb;
            OP_AND:  res = opa & opb;
            OP_OR:   res = opa | opb;
            OP_GTZ:  res = {{(DW-1){1'b0}}, ($signed(opa) > 0)};
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/svec_engine.sv
module svec_engine
    import svec_pkg::*;
#(
    parameter  int DW   = 16,
    parameter  int AW   = 8,
    parameter  int SW   = 8,
    parameter  int MAXN = 32,
    localparam int LW   = $clog2(MAXN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [1:0]    cmd_form,
    input  logic          cmd_mask_en,
    input  logic [DW-1:0] cmd_scalar,
    input  logic [AW-1:0] a_base,
    input  logic [SW-1:0] a_stride,
    input  logic [LW-1:0] a_len,
    input  logic [AW-1:0] b_base,
    input  logic [SW-1:0] b_stride,
    input  logic [LW-1:0] b_len,
    input  logic [AW-1:0] d_base,
    input  logic [SW-1:0] d_stride,
    input  logic [LW-1:0] d_len,
    input  logic          mem_we,
    input  logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic [DW-1:0] result
);
    localparam int IW    = $clog2(MAXN);
    localparam int DEPTH = 1 << AW;

    vstate_e       st_q, st_d;
    logic [DW-1:0] mem   [DEPTH];
    logic [DW-1:0] buf_a [MAXN];
    logic [DW-1:0] buf_b [MAXN];

    vop_e          op_q;
    vform_e        fm_q;
    logic          men_q;
    logic [DW-1:0] scal_q;
    logic [AW-1:0] base_q [NUM_DESC];
    logic [SW-1:0] strd_q [NUM_DESC];
    logic [AW-1:0] addr   [NUM_DESC];
    logic [LW-1:0] n_q;
    logic [IW-1:0] idx_q;
    logic          err_q;
    logic [MAXN-1:0] mask_q, mask_nx;
    logic [DW-1:0] acc_q, acc_d;
    logic [DW-1:0] alu_x, alu_y, alu_r;

    logic len_ok, shape_ok, cmd_ok, accept, last, is_red, st_we;

    // command legality
    always_comb begin
        len_ok = (a_len != '0) && (a_len <= LW'(MAXN));
        unique case (vform_e'(cmd_form))
            FM_VVV:  shape_ok = (b_len == a_len) && (d_len == a_len);
            FM_VSV:  shape_ok = (d_len == a_len);
            FM_RED1: shape_ok = 1'b1;
            FM_RED2: shape_ok = (b_len == a_len);
        endcase
        cmd_ok = len_ok && shape_ok && (cmd_op <= 3'(OP_GTZ));
    end

    assign accept = cmd_valid && (st_q == S_IDLE);
    assign last   = (LW'(idx_q) == (n_q - LW'(1)));
    assign is_red = (fm_q == FM_RED1) || (fm_q == FM_RED2);

    // address generators, one per descriptor
    for (genvar g = 0; g < NUM_DESC; g++) begin : g_agu
        svec_agu #(.AW(AW), .SW(SW), .IW(IW)) u_agu (
            .base   (base_q[g]),
            .stride (strd_q[g]),
            .idx    (idx_q),
            .addr   (addr[g])
        );
    end

    // operand selection and accumulator update
    always_comb begin
        if ((fm_q == FM_RED1) && (op_q != OP_GTZ)) begin
            alu_x = acc_q;
            alu_y = buf_a[idx_q];
        end else begin
            alu_x = buf_a[idx_q];
            alu_y = buf_b[idx_q];
        end
        if ((fm_q == FM_RED1) && (op_q != OP_GTZ)) acc_d = alu_r;
        else                                       acc_d = acc_q + alu_r;
    end

    svec_alu #(.DW(DW)) u_alu (
        .op  (op_q),
        .opa (alu_x),
        .opb (alu_y),
        .res (alu_r)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:   if (accept) st_d = cmd_ok ? S_LOAD : S_FINISH;
            S_LOAD:   if (last)   st_d = S_EXEC;
            S_EXEC:   if (last)   st_d = is_red ? S_FINISH : S_STORE;
            S_STORE:  if (last)   st_d = S_FINISH;
            S_FINISH: st_d = S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        busy  = (st_q != S_IDLE);
        done  = (st_q == S_FINISH);
        error = done && err_q;
        st_we = (st_q == S_STORE) && (!men_q || mask_q[idx_q]);
    end

    assign mem_rdata = mem[mem_addr];

    // control and sequencing registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_ADD;
            fm_q    <= FM_VVV;
            men_q   <= 1'b0;
            scal_q  <= '0;
            n_q     <= '0;
            idx_q   <= '0;
            err_q   <= 1'b0;
            acc_q   <= '0;
            result  <= '0;
            mask_q  <= '1;
            mask_nx <= '0;
            for (int i = 0; i < NUM_DESC; i++) begin
                base_q[i] <= '0;
                strd_q[i] <= '0;
            end
        end else begin
            unique case (st_q)
                S_IDLE: if (accept) begin
                    op_q      <= vop_e'(cmd_op);
                    fm_q      <= vform_e'(cmd_form);
                    men_q     <= cmd_mask_en;
                    scal_q    <= cmd_scalar;
                    n_q       <= a_len;
                    err_q     <= !cmd_ok;
                    idx_q     <= '0;
                    acc_q     <= '0;
                    mask_nx   <= '0;
                    base_q[0] <= a_base;  strd_q[0] <= a_stride;
                    base_q[1] <= b_base;  strd_q[1] <= b_stride;
                    base_q[2] <= d_base;  strd_q[2] <= d_stride;
                end
                S_LOAD: idx_q <= last ? '0 : idx_q + 1'b1;
                S_EXEC: begin
                    idx_q <= last ? '0 : idx_q + 1'b1;
                    acc_q <= acc_d;
                    if (is_red && last) result <= acc_d;
                    if (!is_red && (op_q == OP_GTZ)) mask_nx[idx_q] <= alu_r[0];
                end
                S_STORE: begin
                    idx_q <= last ? '0 : idx_q + 1'b1;
                    if (last && (op_q == OP_GTZ)) mask_q <= mask_nx;
                end
                default: ;
            endcase
        end
    end

    // operand buffers: filled in LOAD, results overwrite in EXEC
    always_ff @(posedge clk) begin
        if (st_q == S_LOAD) begin
            buf_a[idx_q] <= mem[addr[0]];
            buf_b[idx_q] <= (fm_q == FM_VSV) ? scal_q : mem[addr[1]];
        end else if ((st_q == S_EXEC) && !is_red) begin
            buf_a[idx_q] <= alu_r;
        end
    end

    // single memory write path: engine store or idle host write
    always_ff @(posedge clk) begin
        if (st_we)
            mem[addr[2]] <= buf_a[idx_q];
        else if (mem_we && (st_q == S_IDLE))
            mem[mem_addr] <= mem_wdata;
    end

endmodule

// File: rtl/svec_engine_chk.sv
module svec_engine_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [2:0]    cmd_op,
    input logic          busy,
    input logic          done,
    input logic          error,
    input logic [DW-1:0] result,
    input logic          st_we
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R10
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);  // R10
    AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));  // R10
    AST_BAD_OP_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && (cmd_op > 3'd4)) |=> (done && error));  // R2
    AST_ERROR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);  // R2
    AST_STORE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> (busy && !done));  // R11
    AST_RESULT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(result));  // R12
endmodule

bind svec_engine svec_engine_chk #(.DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .result    (result),
    .st_we     (st_we)
);

// File: tb/svec_engine_tb.sv
`timescale 1ns/1ps
module svec_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [1:0]  cmd_form = '0;
    logic        cmd_mask_en = 1'b0;
    logic [15:0] cmd_scalar = '0;
    logic [7:0]  a_base = '0, b_base = '0, d_base = '0;
    logic [7:0]  a_stride = '0, b_stride = '0, d_stride = '0;
    logic [5:0]  a_len = '0, b_len = '0, d_len = '0;
    logic        mem_we = 1'b0;
    logic [7:0]  mem_addr = '0;
    logic [15:0] mem_wdata = '0;
    logic [15:0] mem_rdata;
    logic        busy, done, error;
    logic [15:0] result;

    always #4 clk = ~clk;

    svec_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_form(cmd_form), .cmd_mask_en(cmd_mask_en), .cmd_scalar(cmd_scalar),
        .a_base(a_base), .a_stride(a_stride), .a_len(a_len),
        .b_base(b_base), .b_stride(b_stride), .b_len(b_len),
        .d_base(d_base), .d_stride(d_stride), .d_len(d_len),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .error(error),
        .result(result)
    );

    int          n_run = 0;
    int          n_fail = 0;
    logic [15:0] mm [256];
    logic [31:0] mmask = '1;
    logic [15:0] last_res = '0;

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic logic [15:0] f_alu(input int op, input logic [15:0] x, input logic [15:0] y);
        case (op)
            0: return x + y;
            1: return x - y;
            2: return x & y;
            3: return x | y;
            default: return ($signed(x) > 0) ? 16'd1 : 16'd0;
        endcase
    endfunction

    function automatic logic [7:0] ea(input logic [7:0] b, input int s, input int k);
        return 8'(int'(b) + k * s);
    endfunction

    task automatic mem_compare(input string tag);
        int bad = -1;
        logic [15:0] got = '0;
        for (int i = 0; i < 256; i++) begin
            mem_addr = 8'(i);
            #1;
            if (bad < 0 && mem_rdata !== mm[i]) begin
                bad = i;
                got = mem_rdata;
            end
        end
        check(bad < 0, {tag, " memory image"}, (bad < 0) ? 0 : longint'(got),
              (bad < 0) ? 0 : longint'(mm[bad]));
    endtask

    task automatic run_cmd(input int op, input int form, input bit men, input logic [15:0] sc,
                           input logic [7:0] ab, input int as, input logic [7:0] bb, input int bs,
                           input logic [7:0] db, input int ds,
                           input int al, input int bl, input int dl,
                           input bit poke, input string tag);
        logic [15:0] va [32];
        logic [15:0] vb [32];
        logic [15:0] ve [32];
        logic [31:0] nm;
        logic [15:0] acc;
        bit valid, shape, busy_ok;
        int exp_cyc, cyc;
        case (form)
            0: shape = (bl == al) && (dl == al);
            1: shape = (dl == al);
            2: shape = 1'b1;
            default: shape = (bl == al);
        endcase
        valid = (al != 0) && (al <= 32) && (op <= 4) && shape;
        exp_cyc = 0;
        if (valid) begin
            for (int k = 0; k < al; k++) begin
                va[k] = mm[ea(ab, as, k)];
                vb[k] = (form == 1) ? sc : mm[ea(bb, bs, k)];
            end
            if (form < 2) begin
                nm = '0;
                for (int k = 0; k < al; k++) begin
                    ve[k] = f_alu(op, va[k], vb[k]);
                    if (op == 4) nm[k] = ve[k][0];
                end
                for (int k = 0; k < al; k++)
                    if (!men || mmask[k]) mm[ea(db, ds, k)] = ve[k];
                if (op == 4) mmask = nm;
                exp_cyc = 3 * al;
            end else begin
                acc = '0;
                for (int k = 0; k < al; k++) begin
                    if (form == 2)
                        acc = (op == 4) ? acc + f_alu(4, va[k], 16'd0) : f_alu(op, acc, va[k]);
                    else
                        acc = acc + f_alu(op, va[k], vb[k]);
                end
                last_res = acc;
                exp_cyc = 2 * al;
            end
        end
        cmd_op = 3'(op); cmd_form = 2'(form); cmd_mask_en = men; cmd_scalar = sc;
        a_base = ab; a_stride = 8'(as); a_len = 6'(al);
        b_base = bb; b_stride = 8'(bs); b_len = 6'(bl);
        d_base = db; d_stride = 8'(ds); d_len = 6'(dl);
        cmd_valid = 1'b1;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        cyc = 0;
        busy_ok = 1'b1;
        while (!done && cyc < 400) begin
            if (!busy) busy_ok = 1'b0;
            if (poke && cyc == 2 * al + 1) begin
                mem_we = 1'b1; mem_addr = db; mem_wdata = 16'hdead;
                cmd_valid = 1'b1; cmd_op = 3'd7;
            end else begin
                mem_we = 1'b0; cmd_valid = 1'b0;
            end
            @(posedge clk); #1;
            cyc++;
        end
        mem_we = 1'b0; cmd_valid = 1'b0;
        check(cyc == exp_cyc, {tag, " R9 cycles to done"}, cyc, exp_cyc);
        check(busy_ok && busy, {tag, " R10 busy held until done"}, busy, 1);
        check(error == !valid, {tag, " R2 error flag"}, error, !valid);
        check(result === last_res, {tag, " R12 result"}, result, last_res);
        @(posedge clk); #1;
        check(!busy && !done, {tag, " R10 idle after done"}, {busy, done}, 0);
        mem_compare(tag);
        if (poke) begin
            bit extra = 1'b0;
            repeat (3) begin
                @(posedge clk); #1;
                if (done) extra = 1'b1;
            end
            check(!extra, {tag, " R10 ignored command gave no done"}, extra, 0);
        end
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog R10 actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        check(!busy && !done && !error, "R10 reset outputs", {busy, done, error}, 0);
        check(result == 16'd0, "R12 reset result", result, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 256; i++) begin
            mm[i] = 16'(i * 613 - 9000);
            mem_we = 1'b1; mem_addr = 8'(i); mem_wdata = mm[i];
            @(posedge clk); #1;
        end
        mem_we = 1'b0;
        mem_compare("R11 preload readback");

        // masked store before any compare: reset mask is all ones
        run_cmd(0, 0, 1'b1, 16'd0, 8'd10, 1, 8'd40, 1, 8'd120, 1, 8, 8, 8, 1'b0, "R7 R8 reset mask");
        // destination one ahead of source: vector semantics
        run_cmd(0, 1, 1'b0, 16'd1, 8'd60, 1, 8'd0, 0, 8'd61, 1, 12, 0, 12, 1'b0, "R6 overlap ahead");
        run_cmd(1, 1, 1'b0, 16'd3, 8'd90, 1, 8'd0, 0, 8'd89, 1, 12, 0, 12, 1'b0, "R6 overlap behind");
        // descending strides crossing address 0
        run_cmd(0, 0, 1'b0, 16'd0, 8'd2, -3, 8'd250, 7, 8'd5, -1, 10, 10, 10, 1'b0, "R1 wrap");
        // rejects
        run_cmd(0, 0, 1'b0, 16'd0, 8'd0, 1, 8'd50, 1, 8'd100, 1, 8, 7, 8, 1'b0, "R2 form0 mismatch");
        run_cmd(0, 1, 1'b0, 16'd0, 8'd0, 1, 8'd50, 1, 8'd100, 1, 8, 0, 9, 1'b0, "R2 form1 mismatch");
        run_cmd(0, 3, 1'b0, 16'd0, 8'd0, 1, 8'd50, 1, 8'd100, 1, 5, 6, 0, 1'b0, "R2 form3 mismatch");
        run_cmd(0, 2, 1'b0, 16'd0, 8'd0, 1, 8'd50, 1, 8'd100, 1, 0, 0, 0, 1'b0, "R2 zero length");
        run_cmd(0, 2, 1'b0, 16'd0, 8'd0, 1, 8'd50, 1, 8'd100, 1, 33, 33, 33, 1'b0, "R2 length 33");
        run_cmd(5, 0, 1'b0, 16'd0, 8'd0, 1, 8'd50, 1, 8'd100, 1, 8, 8, 8, 1'b0, "R2 opcode 5");
        // host write and new command during STORE
        run_cmd(0, 0, 1'b0, 16'd0, 8'd20, 1, 8'd70, 2, 8'd140, 1, 8, 8, 8, 1'b1, "R10 R11 busy collision");

        // sweep: operations x forms x lengths x strides x mask
        for (int op = 0; op < 5; op++)
            for (int form = 0; form < 4; form++)
                for (int li = 0; li < 3; li++)
                    for (int s = 0; s < 3; s++)
                        for (int men = 0; men < 2; men++) begin
                            int n  = (li == 0) ? 1 : (li == 1) ? 7 : 32;
                            int sa = (s == 0) ? 1 : (s == 1) ? -1 : 5;
                            int sb = (s == 0) ? 1 : (s == 1) ? 3 : -7;
                            int sd = (s == 0) ? 1 : (s == 1) ? 2 : -3;
                            string tag = (form < 2) ? "R1 R3 R7 R8" : (form == 2) ? "R4" : "R5";
                            run_cmd(op, form, men[0], 16'(s * 1234 - 999 + op),
                                    8'(17 * op + 3 * form + men), sa,
                                    8'(200 + 5 * s), sb,
                                    8'(100 + 11 * n + men), sd,
                                    n, n, n, 1'b0, tag);
                        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule